// File: doc/BRIEF.md
# Event-Counting Performance Monitor

This block watches a bus of single-cycle event strobes coming from an accelerator and accumulates them. It has four general 32-bit event counters and one 64-bit cycle counter. Each general counter picks its event through a 10-bit event number. The cycle counter can be opened and closed by a start event and a stop event, so that it times only a stretch of work of interest.

Software reaches every piece of state through a plain 32-bit register port. Each transfer takes one cycle: the write is applied at the clock edge, and the read data follows the address combinationally. A single level interrupt is raised while an enabled counter has overflowed. There is no streaming data path. Strobes, register port and interrupt are all plain control and status pins, with no valid/ready handshake and no back-pressure.

Event numbers are decoded as follows:
- 0 is "no event".
- 1 is the clock and is true on every cycle.
- 2 up to NUM_EVT+1 select `evt_strobe[n-2]`.
- Any larger number never fires.

Top module: `pmu_monitor`

## Requirements
- R1: After reset every counter, mask, event select and configuration field reads 0, the global enable is 0 and `irq` is low.
- R2: The register map uses word addresses. 0x00 is control. 0x01/0x02 set/clear counter enable, 0x03/0x04 set/clear overflow, and 0x05/0x06 set/clear interrupt enable. 0x08/0x09 hold the low/high cycle-counter halves and 0x0A is the cycle configuration. 0x10+i is counter i and 0x18+i is the event select of counter i (bits [9:0]). Unmapped addresses read 0.
- R3: A general counter increments by one in a cycle only if control bit 0 (global enable) is 1, its enable bit is 1, and its selected event is true. Event 0 and numbers above NUM_EVT+1 never count, event 1 counts every cycle, and event n selects `evt_strobe[n-2]`.
- R4: Writing control with bit 1 set zeroes all general counters at that edge, and bit 2 zeroes the cycle counter. Both bits are self-clearing, and control reads back only bit 0.
- R5: All three masks share one layout: bit i (0..3) is general counter i and bit 31 is the cycle counter. A write to a set address ORs the written ones in, and a write to a clear address removes them. Both addresses read the current mask.
- R6: When a counter increments from all ones to zero, its overflow bit is set. The bit stays set until a 1 is written to it at the overflow clear address. If a wrap and a clear hit the same bit in one cycle, the bit ends up set.
- R7: `irq` is high exactly when some overflow bit is set and the interrupt enable bit at the same position is also set.
- R8: Counter values are writable. For the cycle counter this is done half by half through 0x08 and 0x09. A write wins over an increment in the same cycle, and a control reset wins over a write.
- R9: The cycle configuration holds the start event number in bits [9:0] and the stop event number in bits [25:16]. With start 0, the cycle counter counts on every enabled cycle. Otherwise a start event arms it from the next cycle on, a stop event disarms it from the next cycle on (start wins if both fire), and a configuration write disarms it.
- R10: The cycle counter carries from its low half into its high half. Its 64-bit wrap sets overflow bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | NUM_EVT | Event strobes, one cycle each |
| reg_addr | input | 6 | Register word address |
| reg_wr | input | 1 | Write enable, applied at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt for enabled overflows |

## Verification
The bench builds the block with its defaults: four counters of 32 bits, a 64-bit cycle counter and sixteen strobes. This makes event numbers 2 to 17 live and leaves 18 to 1023 as dead numbers to probe. Counters are preloaded close to all ones, so 32-bit and 64-bit wraps, the carry between the halves, and the overflow-to-interrupt path all occur within a few cycles. Random strobes and register writes then run against a cycle-level reference model, which reaches combinations such as a wrap colliding with a clear, or a write colliding with an increment.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int REG_AW = 6;
  localparam int EVT_NUM_W = 10;
  localparam int EVT_STROBE_BASE = 2;

  typedef logic [REG_AW-1:0] reg_addr_t;
  typedef logic [EVT_NUM_W-1:0] evt_num_t;

  localparam reg_addr_t A_CTRL     = 6'h00;
  localparam reg_addr_t A_EN_SET   = 6'h01;
  localparam reg_addr_t A_EN_CLR   = 6'h02;
  localparam reg_addr_t A_OVF_SET  = 6'h03;
  localparam reg_addr_t A_OVF_CLR  = 6'h04;
  localparam reg_addr_t A_IEN_SET  = 6'h05;
  localparam reg_addr_t A_IEN_CLR  = 6'h06;
  localparam reg_addr_t A_CYC_LO   = 6'h08;
  localparam reg_addr_t A_CYC_HI   = 6'h09;
  localparam reg_addr_t A_CYC_CFG  = 6'h0A;
  localparam reg_addr_t A_CTR_BASE = 6'h10;
  localparam reg_addr_t A_SEL_BASE = 6'h18;

  localparam int CTRL_EN_BIT     = 0;
  localparam int CTRL_RST_EV_BIT = 1;
  localparam int CTRL_RST_CY_BIT = 2;
  localparam int CYC_MASK_BIT    = 31;
  localparam int START_LSB       = 0;
  localparam int STOP_LSB        = 16;

  localparam evt_num_t EVT_NONE  = '0;
  localparam evt_num_t EVT_CLOCK = 10'd1;

endpackage

// File: rtl/pmu_event_select.sv
module pmu_event_select
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 16
) (
  input  logic [NUM_EVT-1:0] strobes,
  input  evt_num_t           sel,
  output logic               hit
);

  always_comb begin
    hit = 1'b0;
    if (sel == EVT_CLOCK) begin
      hit = 1'b1;
    end else begin
      for (int k = 0; k < NUM_EVT; k++) begin
        if (sel == evt_num_t'(k + EVT_STROBE_BASE)) hit = strobes[k];
      end
    end
  end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         wrap
);

  assign wrap = inc && !clr && !ld && (&q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q + W'(1);
  end

endmodule

// File: rtl/pmu_mask_reg.sv
module pmu_mask_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);

  logic [W-1:0] set_v, clr_v;

  assign set_v = set_we ? bits : '0;
  assign clr_v = clr_we ? bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_v) | set_v | hw_set;
  end

endmodule

// File: rtl/pmu_cycle_gate.sv
module pmu_cycle_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic start_none,
  input  logic start_hit,
  input  logic stop_hit,
  input  logic cfg_wr,
  output logic active
);

  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        run_q <= 1'b0;
    else if (cfg_wr)                   run_q <= 1'b0;
    else if (!start_none && start_hit) run_q <= 1'b1;
    else if (stop_hit)                 run_q <= 1'b0;
  end

  assign active = start_none || run_q;

endmodule

// File: rtl/pmu_monitor.sv
module pmu_monitor
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int DW      = 32,
  parameter int CTR_W   = 32,
  parameter int NUM_EVT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               irq
);

  localparam int MW      = NUM_CTR + 1;
  localparam int CYC_IDX = NUM_CTR;
  localparam int CYC_W   = 2 * DW;

  logic                          en_q;
  evt_num_t                      sel_q [NUM_CTR];
  evt_num_t                      start_q, stop_q;
  logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q;
  logic [CYC_W-1:0]              cyc_q;
  logic [MW-1:0]                 cnten_q, ovf_q, ien_q, wrap_v, wmask;
  logic [NUM_CTR-1:0]            hit_v;
  logic                          wr_ctrl, rst_ev, rst_cy, wr_lo, wr_hi, wr_cfg;
  logic                          start_hit, stop_hit, cyc_active, cyc_wrap;
  logic [CYC_W-1:0]              cyc_ld_val;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign rst_ev  = wr_ctrl && reg_wdata[CTRL_RST_EV_BIT];
  assign rst_cy  = wr_ctrl && reg_wdata[CTRL_RST_CY_BIT];
  assign wr_lo   = reg_wr && (reg_addr == A_CYC_LO);
  assign wr_hi   = reg_wr && (reg_addr == A_CYC_HI);
  assign wr_cfg  = reg_wr && (reg_addr == A_CYC_CFG);
  assign wmask   = {reg_wdata[CYC_MASK_BIT], reg_wdata[NUM_CTR-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      start_q <= EVT_NONE;
      stop_q  <= EVT_NONE;
    end else begin
      if (wr_ctrl) en_q <= reg_wdata[CTRL_EN_BIT];
      if (wr_cfg) begin
        start_q <= reg_wdata[START_LSB +: EVT_NUM_W];
        stop_q  <= reg_wdata[STOP_LSB +: EVT_NUM_W];
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
      logic wr_sel, wr_val;
      assign wr_sel = reg_wr && (reg_addr == A_SEL_BASE + reg_addr_t'(gi));
      assign wr_val = reg_wr && (reg_addr == A_CTR_BASE + reg_addr_t'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q[gi] <= EVT_NONE;
        else if (wr_sel) sel_q[gi] <= reg_wdata[EVT_NUM_W-1:0];
      end

      pmu_event_select #(.NUM_EVT(NUM_EVT)) u_sel (
        .strobes (evt_strobe),
        .sel     (sel_q[gi]),
        .hit     (hit_v[gi])
      );

      pmu_counter #(.W(CTR_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rst_ev),
        .ld     (wr_val),
        .ld_val (reg_wdata[CTR_W-1:0]),
        .inc    (en_q && cnten_q[gi] && hit_v[gi]),
        .q      (ctr_q[gi]),
        .wrap   (wrap_v[gi])
      );
    end
  endgenerate

  pmu_event_select #(.NUM_EVT(NUM_EVT)) u_start_sel (
    .strobes (evt_strobe),
    .sel     (start_q),
    .hit     (start_hit)
  );

  pmu_event_select #(.NUM_EVT(NUM_EVT)) u_stop_sel (
    .strobes (evt_strobe),
    .sel     (stop_q),
    .hit     (stop_hit)
  );

  pmu_cycle_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_none (start_q == EVT_NONE),
    .start_hit  (start_hit),
    .stop_hit   (stop_hit),
    .cfg_wr     (wr_cfg),
    .active     (cyc_active)
  );

  assign cyc_ld_val = wr_lo ? {cyc_q[CYC_W-1:DW], reg_wdata}
                            : {reg_wdata, cyc_q[DW-1:0]};

  pmu_counter #(.W(CYC_W)) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (rst_cy),
    .ld     (wr_lo || wr_hi),
    .ld_val (cyc_ld_val),
    .inc    (en_q && cnten_q[CYC_IDX] && cyc_active),
    .q      (cyc_q),
    .wrap   (cyc_wrap)
  );

  assign wrap_v[CYC_IDX] = cyc_wrap;

  pmu_mask_reg #(.W(MW)) u_cnten (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (reg_wr && reg_addr == A_EN_SET),
    .clr_we (reg_wr && reg_addr == A_EN_CLR),
    .bits   (wmask),
    .hw_set ('0),
    .q      (cnten_q)
  );

  pmu_mask_reg #(.W(MW)) u_ovf (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (reg_wr && reg_addr == A_OVF_SET),
    .clr_we (reg_wr && reg_addr == A_OVF_CLR),
    .bits   (wmask),
    .hw_set (wrap_v),
    .q      (ovf_q)
  );

  pmu_mask_reg #(.W(MW)) u_ien (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (reg_wr && reg_addr == A_IEN_SET),
    .clr_we (reg_wr && reg_addr == A_IEN_CLR),
    .bits   (wmask),
    .hw_set ('0),
    .q      (ien_q)
  );

  assign irq = |(ovf_q & ien_q);

  function automatic logic [DW-1:0] spread(input logic [MW-1:0] m);
    logic [DW-1:0] r;
    r = '0;
    r[NUM_CTR-1:0]  = m[NUM_CTR-1:0];
    r[CYC_MASK_BIT] = m[CYC_IDX];
    return r;
  endfunction

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:                reg_rdata[CTRL_EN_BIT] = en_q;
      A_EN_SET,  A_EN_CLR:   reg_rdata = spread(cnten_q);
      A_OVF_SET, A_OVF_CLR:  reg_rdata = spread(ovf_q);
      A_IEN_SET, A_IEN_CLR:  reg_rdata = spread(ien_q);
      A_CYC_LO:              reg_rdata = cyc_q[DW-1:0];
      A_CYC_HI:              reg_rdata = cyc_q[CYC_W-1:DW];
      A_CYC_CFG: begin
        reg_rdata[START_LSB +: EVT_NUM_W] = start_q;
        reg_rdata[STOP_LSB +: EVT_NUM_W]  = stop_q;
      end
      default: begin
        for (int i = 0; i < NUM_CTR; i++) begin
          if (reg_addr == A_CTR_BASE + reg_addr_t'(i)) reg_rdata = DW'(ctr_q[i]);
          if (reg_addr == A_SEL_BASE + reg_addr_t'(i)) reg_rdata = DW'(sel_q[i]);
        end
      end
    endcase
  end

endmodule

// File: rtl/pmu_monitor_chk.sv
module pmu_monitor_chk
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int DW      = 32,
  parameter int CTR_W   = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [REG_AW-1:0]             reg_addr,
  input logic                          reg_wr,
  input logic [DW-1:0]                 reg_wdata,
  input logic                          irq,
  input logic                          en_q,
  input logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q,
  input logic [2*DW-1:0]               cyc_q,
  input logic [NUM_CTR:0]              ovf_q,
  input logic [NUM_CTR:0]              ien_q
);

  // R4
  ev_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL && reg_wdata[CTRL_RST_EV_BIT]) |=> (ctr_q == '0));

  // R4
  cyc_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL && reg_wdata[CTRL_RST_CY_BIT]) |=> (cyc_q == '0));

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reg_wr) |=> ($stable(ctr_q) && $stable(cyc_q)));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_OVF_CLR) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  // R7
  irq_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q == '0) |-> !irq);

endmodule

bind pmu_monitor pmu_monitor_chk #(
  .NUM_CTR (NUM_CTR),
  .DW      (DW),
  .CTR_W   (CTR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .en_q      (en_q),
  .ctr_q     (ctr_q),
  .cyc_q     (cyc_q),
  .ovf_q     (ovf_q),
  .ien_q     (ien_q)
);

// File: tb/pmu_monitor_tb.sv
`timescale 1ns/1ps
module pmu_monitor_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          failures = 0;

  always #2 clk = ~clk;

  pmu_monitor u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_strobe (evt),
    .reg_addr   (addr),
    .reg_wr     (wr),
    .reg_wdata  (wdata),
    .reg_rdata  (rdata),
    .irq        (irq)
  );

  // reference model state
  bit        m_en;
  bit [4:0]  m_cnten, m_ovf, m_ien;
  bit [31:0] m_ctr [4];
  bit [63:0] m_cyc;
  bit [9:0]  m_sel [4];
  bit [9:0]  m_start, m_stop;
  bit        m_run;

  function automatic bit mhit(input bit [9:0] s, input bit [15:0] e);
    if (s == 10'd0) return 1'b0;
    if (s == 10'd1) return 1'b1;
    if (s < 10'd18) return e[s - 10'd2];
    return 1'b0;
  endfunction

  function automatic bit [31:0] pack(input bit [4:0] c);
    return {c[4], 27'd0, c[3:0]};
  endfunction

  function automatic bit [31:0] exp_read(input bit [5:0] a);
    case (a)
      6'h00: return {31'd0, m_en};
      6'h01, 6'h02: return pack(m_cnten);
      6'h03, 6'h04: return pack(m_ovf);
      6'h05, 6'h06: return pack(m_ien);
      6'h08: return m_cyc[31:0];
      6'h09: return m_cyc[63:32];
      6'h0A: return {6'd0, m_stop, 6'd0, m_start};
      6'h10, 6'h11, 6'h12, 6'h13: return m_ctr[a - 6'h10];
      6'h18, 6'h19, 6'h1A, 6'h1B: return {22'd0, m_sel[a - 6'h18]};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model_step
    bit [4:0] hw;
    bit [4:0] cw;
    bit       wctl, inc, act, nrun;
    if (!rst_n) begin
      m_en = 0; m_cnten = 0; m_ovf = 0; m_ien = 0; m_cyc = 0;
      m_start = 0; m_stop = 0; m_run = 0;
      for (int i = 0; i < 4; i++) begin m_ctr[i] = 0; m_sel[i] = 0; end
    end else begin
      hw = 0;
      cw = {wdata[31], wdata[3:0]};
      wctl = wr && addr == 6'h00;
      for (int i = 0; i < 4; i++) begin
        inc = m_en && m_cnten[i] && mhit(m_sel[i], evt);
        if (wctl && wdata[1]) m_ctr[i] = 0;
        else if (wr && addr == 6'h10 + 6'(i)) m_ctr[i] = wdata;
        else if (inc) begin
          if (m_ctr[i] == 32'hFFFF_FFFF) hw[i] = 1'b1;
          m_ctr[i] = m_ctr[i] + 1;
        end
      end
      act = (m_start == 0) || m_run;
      inc = m_en && m_cnten[4] && act;
      if (wctl && wdata[2]) m_cyc = 0;
      else if (wr && addr == 6'h08) m_cyc[31:0] = wdata;
      else if (wr && addr == 6'h09) m_cyc[63:32] = wdata;
      else if (inc) begin
        if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) hw[4] = 1'b1;
        m_cyc = m_cyc + 1;
      end
      nrun = m_run;
      if (wr && addr == 6'h0A) nrun = 0;
      else if (m_start != 0 && mhit(m_start, evt)) nrun = 1;
      else if (mhit(m_stop, evt)) nrun = 0;
      m_run = nrun;
      if (wr && addr == 6'h01) m_cnten = m_cnten | cw;
      if (wr && addr == 6'h02) m_cnten = m_cnten & ~cw;
      if (wr && addr == 6'h04) m_ovf = m_ovf & ~cw;
      if (wr && addr == 6'h03) m_ovf = m_ovf | cw;
      m_ovf = m_ovf | hw;
      if (wr && addr == 6'h05) m_ien = m_ien | cw;
      if (wr && addr == 6'h06) m_ien = m_ien & ~cw;
      for (int i = 0; i < 4; i++)
        if (wr && addr == 6'h18 + 6'(i)) m_sel[i] = wdata[9:0];
      if (wr && addr == 6'h0A) begin m_start = wdata[9:0]; m_stop = wdata[25:16]; end
      if (wctl) m_en = wdata[0];
    end
  end

  task automatic drive(input bit w, input bit [5:0] a, input bit [31:0] d, input bit [15:0] e);
    @(negedge clk);
    wr = w; addr = a; wdata = d; evt = e;
  endtask

  task automatic wreg(input bit [5:0] a, input bit [31:0] d);
    drive(1'b1, a, d, 16'd0);
  endtask

  task automatic idle(input int n, input bit [15:0] e);
    for (int k = 0; k < n; k++) drive(1'b0, 6'h3F, 32'd0, e);
  endtask

  task automatic chk(input bit [5:0] a, input string req);
    bit [31:0] exp;
    bit        exp_irq;
    @(negedge clk);
    wr = 0; addr = a; evt = 0;
    #1;
    exp = exp_read(a);
    exp_irq = |(m_ovf & m_ien);
    checks++;
    if (rdata !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata, exp);
    end
    checks++;
    if (irq !== exp_irq) begin
      failures++;
      $display("FAIL R7 irq (%s) actual=%b expected=%b", req, irq, exp_irq);
    end
  endtask

  task automatic chk_all(input string req);
    for (int a = 0; a < 32; a++) chk(6'(a), req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_all("R1");

    // R2 R11-style readback of selects and config, R4 control reads only bit 0
    wreg(6'h18, 32'd1); wreg(6'h19, 32'd2); wreg(6'h1A, 32'd0); wreg(6'h1B, 32'd1023);
    wreg(6'h0A, {6'd0, 10'd4, 6'd0, 10'd3});
    chk(6'h18, "R2"); chk(6'h1B, "R2"); chk(6'h0A, "R9");
    wreg(6'h00, 32'h0000_0007);
    chk(6'h00, "R4");
    wreg(6'h0A, 32'd0);

    // R5 set/clear masks
    wreg(6'h01, 32'h8000_000F);
    chk(6'h01, "R5"); chk(6'h02, "R5");
    wreg(6'h02, 32'h0000_0004);
    chk(6'h01, "R5");
    wreg(6'h01, 32'h0000_0004);

    // R3 event selection: clock, strobe0, none, unmapped
    idle(10, 16'h0001);
    idle(7, 16'h0000);
    idle(5, 16'hFFFE);
    chk(6'h10, "R3"); chk(6'h11, "R3"); chk(6'h12, "R3"); chk(6'h13, "R3");
    chk(6'h08, "R3");
    // R3 global enable off freezes counts
    wreg(6'h00, 32'd0);
    idle(6, 16'hFFFF);
    chk(6'h10, "R3"); chk(6'h11, "R3"); chk(6'h08, "R3");

    // R4 reset bits
    wreg(6'h00, 32'd3);
    chk(6'h10, "R4"); chk(6'h08, "R4");
    wreg(6'h00, 32'd5);
    chk(6'h08, "R4"); chk(6'h00, "R4");

    // R6 R7 wrap, overflow, interrupt
    wreg(6'h10, 32'hFFFF_FFFE);
    idle(3, 16'd0);
    chk(6'h10, "R6"); chk(6'h03, "R6");
    wreg(6'h05, 32'd1);
    chk(6'h05, "R7");
    idle(4, 16'd0);
    chk(6'h03, "R6");
    wreg(6'h04, 32'd1);
    chk(6'h03, "R6");
    // R6 wrap colliding with clear
    wreg(6'h10, 32'hFFFF_FFFF);
    wreg(6'h04, 32'd1);
    chk(6'h03, "R6");
    wreg(6'h04, 32'd1);

    // R8 write beats increment
    wreg(6'h10, 32'h1234_5678);
    wreg(6'h10, 32'h0000_0100);
    chk(6'h10, "R8");

    // R10 carry and 64-bit wrap
    wreg(6'h08, 32'hFFFF_FFFD);
    wreg(6'h09, 32'h0000_0000);
    idle(4, 16'd0);
    chk(6'h08, "R10"); chk(6'h09, "R10");
    wreg(6'h08, 32'hFFFF_FFFF);
    wreg(6'h09, 32'hFFFF_FFFF);
    wreg(6'h05, 32'h8000_0000);
    idle(2, 16'd0);
    chk(6'h03, "R10"); chk(6'h09, "R10");
    wreg(6'h04, 32'h8000_0001);

    // R9 start/stop gating (start = strobe1, stop = strobe2)
    wreg(6'h0A, {6'd0, 10'd4, 6'd0, 10'd3});
    wreg(6'h00, 32'd5);
    idle(5, 16'd0);
    chk(6'h08, "R9");
    idle(1, 16'h0002);
    idle(6, 16'd0);
    chk(6'h08, "R9");
    idle(1, 16'h0004);
    idle(5, 16'd0);
    chk(6'h08, "R9");
    idle(1, 16'h0006);
    idle(3, 16'd0);
    chk(6'h08, "R9");

    // random mix against the model
    for (int r = 0; r < 12; r++) begin
      for (int c = 0; c < 150; c++) begin
        bit [31:0] x;
        x = $urandom;
        if (x[3:0] == 4'd0)
          drive(1'b1, 6'($urandom_range(0, 31)), $urandom, 16'($urandom));
        else
          drive(1'b0, 6'h3F, 32'd0, 16'($urandom));
      end
      chk_all("R3 R6 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule